// File: doc/BRIEF.md
# Multi-Channel Stress-Current Controller

This block is the digital control core of a reliability test die. The die carries several identical metal interconnect structures, and each structure is driven by its own binary-weighted current DAC. An external controller selects a channel by shifting an address into the block over one serial line. It then shifts a current code over a second serial line. Each line has its own write strobe. When the code frame completes, the code is stored in the register of the channel currently held in the address register. One code step corresponds to 200 µA of stress current.

A single master enable holds every DAC drive output at zero until the controller raises it. The stored codes are kept while the master enable is low. Each structure reports an open circuit through a fail input. The block latches that report, forces the broken channel's drive to zero, and presents the latched state as a per-channel vector and a combined flag. A strobe that drops before a full frame has been shifted leaves the target register unchanged and raises a frame-error flag.

The intended order of use is: write the address, write the code for that channel, then raise the master enable.

Top module: `stress_ctrl`

## Requirements
- R1: The block holds N_CH (default 8) independent CODE_W-bit (default 7) current codes. Channel k drives bits [k*CODE_W +: CODE_W] of `dac_code`.
- R2: While `addr_we` is high, each rising clock edge shifts `addr_sdi` into the address shift register, MSB first. The edge that first samples `addr_we` low after it was high commits the last $clog2(N_CH) bits to the address register.
- R3: While `code_we` is high, each rising clock edge shifts `code_sdi` in, MSB first. When the strobe falls, the code is stored in the channel selected by the address register. The output shows the new code no later than three clock edges after the falling strobe is sampled.
- R4: A code write always uses the address register value in force when that code frame commits. A later address change does not move codes that are already stored.
- R5: While `master_en` is low, every DAC drive output is zero on the following cycle. Stored codes are retained and reappear once `master_en` is high again.
- R6: Synchronous reset clears all codes, the address register, the fail latches, `any_fail` and `frame_err` to zero.
- R7: A high `fail_in[k]` sets `fail_vec[k]` on the next edge. The bit stays set after `fail_in[k]` returns low.
- R8: A channel with its fail bit set drives zero. A completed code write to that channel clears its fail bit, unless `fail_in` for that channel is still high.
- R9: `any_fail` equals the OR of all `fail_vec` bits.
- R10: A strobe that falls after fewer bits than the register width leaves that register unchanged and sets `frame_err`. The flag clears on the next complete frame on either line.
- R11: A frame longer than the register width keeps only its last register-width bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr_sdi | input | 1 | Serial address data, MSB first |
| addr_we | input | 1 | Address write strobe; its falling edge commits the address |
| code_sdi | input | 1 | Serial current-code data, MSB first |
| code_we | input | 1 | Code write strobe; its falling edge commits the code |
| master_en | input | 1 | Master current enable for all channels |
| fail_in | input | N_CH | Open-circuit reports, one per structure |
| dac_code | output | N_CH*CODE_W | Registered DAC drive codes, channel k at [k*CODE_W +: CODE_W] |
| fail_vec | output | N_CH | Latched per-channel fail status |
| any_fail | output | 1 | OR of all latched fail bits |
| frame_err | output | 1 | A short frame was seen since the last complete frame |

## Verification
The bench builds the block with its default eight channels and 7-bit codes. This gives a 3-bit address, so every channel can be written, including address 0 and address 7. Codes cover the extremes 0 and 127. A 2-bit short address frame and a 10-bit overlong code frame probe the frame-length rules at the real register widths. Fail pulses, rewrites of a failed channel, toggling of the master enable and a mid-run reset are mixed with the writes. This shows that gating, sticky fail state and register contents interact as required.

// File: rtl/stress_pkg.sv
package stress_pkg;
  parameter int DEF_N_CH   = 8;
  parameter int DEF_CODE_W = 7;

  function automatic int addr_bits(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/serial_loader.sv
module serial_loader #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sdi,
  input  logic         we,
  output logic [W-1:0] val,
  output logic         commit,
  output logic         short_frame
);
  localparam int CNT_W = $clog2(W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(W);

  logic             we_q;
  logic [W-1:0]     shreg;
  logic [CNT_W-1:0] cnt;
  logic             fall;

  assign fall = we_q & ~we;

  always_ff @(posedge clk) begin
    if (rst) begin
      we_q        <= 1'b0;
      shreg       <= '0;
      cnt         <= '0;
      val         <= '0;
      commit      <= 1'b0;
      short_frame <= 1'b0;
    end else begin
      we_q        <= we;
      commit      <= 1'b0;
      short_frame <= 1'b0;
      if (we) begin
        shreg <= (shreg << 1) | W'(sdi);
        if (cnt != FULL) cnt <= cnt + 1'b1;
      end else if (fall) begin
        cnt <= '0;
        if (cnt == FULL) begin
          val    <= shreg;
          commit <= 1'b1;
        end else begin
          short_frame <= 1'b1;
        end
      end
    end
  end

  // R10: a short frame never alters the committed value
  p_short_hold_r10: assert property (@(posedge clk) disable iff (rst)
    short_frame |-> $stable(val));
  // R10: a frame ends either complete or short, never both
  p_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(short_frame && commit));
endmodule

// File: rtl/channel_bank.sv
module channel_bank #(
  parameter int N_CH   = 8,
  parameter int CODE_W = 7,
  parameter int ADDR_W = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     master_en,
  input  logic                     wr_stb,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [CODE_W-1:0]        wr_val,
  input  logic [N_CH-1:0]          fail_in,
  output logic [N_CH*CODE_W-1:0]   dac_flat,
  output logic [N_CH-1:0]          fail_vec,
  output logic                     any_fail
);
  logic [N_CH-1:0] fail_nxt;

  for (genvar k = 0; k < N_CH; k++) begin : g_ch
    logic [CODE_W-1:0] code_q;
    logic [CODE_W-1:0] dac_q;
    logic              hit;

    assign hit = wr_stb && (wr_addr == ADDR_W'(k));

    always_comb begin
      if (hit) fail_nxt[k] = fail_in[k];
      else     fail_nxt[k] = fail_vec[k] | fail_in[k];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        code_q      <= '0;
        dac_q       <= '0;
        fail_vec[k] <= 1'b0;
      end else begin
        if (hit) code_q <= wr_val;
        fail_vec[k] <= fail_nxt[k];
        dac_q <= (master_en && !fail_vec[k]) ? code_q : '0;
      end
    end

    assign dac_flat[k*CODE_W +: CODE_W] = dac_q;

    // R7: an observed fail report is latched on the next edge
    p_fail_set_r7: assert property (@(posedge clk) disable iff (rst)
      fail_in[k] |=> fail_vec[k]);
    // R7: latched fail stays without a write to the channel
    p_fail_sticky_r7: assert property (@(posedge clk) disable iff (rst)
      (fail_vec[k] && !hit) |=> fail_vec[k]);
    // R8: a failed channel drives no current
    p_failed_zero_r8: assert property (@(posedge clk) disable iff (rst)
      fail_vec[k] |=> (dac_q == '0));
  end

  always_ff @(posedge clk) begin
    if (rst) any_fail <= 1'b0;
    else     any_fail <= |fail_nxt;
  end

  // R9: combined flag agrees with the vector
  p_any_match_r9: assert property (@(posedge clk) disable iff (rst)
    any_fail == (|fail_vec));
endmodule

// File: rtl/stress_ctrl.sv
module stress_ctrl
  import stress_pkg::*;
#(
  parameter int N_CH   = DEF_N_CH,
  parameter int CODE_W = DEF_CODE_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   addr_sdi,
  input  logic                   addr_we,
  input  logic                   code_sdi,
  input  logic                   code_we,
  input  logic                   master_en,
  input  logic [N_CH-1:0]        fail_in,
  output logic [N_CH*CODE_W-1:0] dac_code,
  output logic [N_CH-1:0]        fail_vec,
  output logic                   any_fail,
  output logic                   frame_err
);
  localparam int ADDR_W = addr_bits(N_CH);

  logic [ADDR_W-1:0] addr_q;
  logic [CODE_W-1:0] code_val;
  logic              a_commit, a_short, c_commit, c_short;

  serial_loader #(.W(ADDR_W)) u_addr (
    .clk(clk), .rst(rst), .sdi(addr_sdi), .we(addr_we),
    .val(addr_q), .commit(a_commit), .short_frame(a_short));

  serial_loader #(.W(CODE_W)) u_code (
    .clk(clk), .rst(rst), .sdi(code_sdi), .we(code_we),
    .val(code_val), .commit(c_commit), .short_frame(c_short));

  channel_bank #(.N_CH(N_CH), .CODE_W(CODE_W), .ADDR_W(ADDR_W)) u_bank (
    .clk(clk), .rst(rst), .master_en(master_en),
    .wr_stb(c_commit), .wr_addr(addr_q), .wr_val(code_val),
    .fail_in(fail_in), .dac_flat(dac_code), .fail_vec(fail_vec),
    .any_fail(any_fail));

  always_ff @(posedge clk) begin
    if (rst)                          frame_err <= 1'b0;
    else if (a_short || c_short)      frame_err <= 1'b1;
    else if (a_commit || c_commit)    frame_err <= 1'b0;
  end

  // R5: master enable low forces every drive output to zero
  p_off_when_disabled_r5: assert property (@(posedge clk) disable iff (rst)
    !master_en |=> (dac_code == '0));
  // R10: a short frame raises the error flag
  p_short_flags_r10: assert property (@(posedge clk) disable iff (rst)
    (a_short || c_short) |=> frame_err);
endmodule

// File: tb/stress_ctrl_test.sv
module stress_ctrl_test;
  localparam int N  = 8;
  localparam int W  = 7;
  localparam int AW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic addr_sdi = 1'b0, addr_we = 1'b0, code_sdi = 1'b0, code_we = 1'b0;
  logic master_en = 1'b0;
  logic [N-1:0]   fail_in = '0;
  logic [N*W-1:0] dac_code;
  logic [N-1:0]   fail_vec;
  logic           any_fail, frame_err;

  always #2 clk = ~clk;

  stress_ctrl #(.N_CH(N), .CODE_W(W)) uut (
    .clk(clk), .rst(rst), .addr_sdi(addr_sdi), .addr_we(addr_we),
    .code_sdi(code_sdi), .code_we(code_we), .master_en(master_en),
    .fail_in(fail_in), .dac_code(dac_code), .fail_vec(fail_vec),
    .any_fail(any_fail), .frame_err(frame_err));

  typedef struct {
    logic [N*W-1:0] dac;
    logic [N-1:0]   fv;
    logic           any;
    logic           ferr;
    string          tag;
  } exp_t;

  exp_t q[$];
  int total = 0, bad = 0;
  bit done = 0;

  int            m_addr;
  logic [W-1:0]  m_code [N];
  logic [N-1:0]  m_fail;
  logic          m_ferr;

  task automatic model_clear();
    m_addr = 0; m_fail = '0; m_ferr = 0;
    for (int k = 0; k < N; k++) m_code[k] = '0;
  endtask

  task automatic push(input string tag);
    exp_t e;
    for (int k = 0; k < N; k++)
      e.dac[k*W +: W] = (master_en && !m_fail[k]) ? m_code[k] : '0;
    e.fv = m_fail; e.any = |m_fail; e.ferr = m_ferr; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic shift_in(input bit is_code, input int val, input int nbits);
    for (int i = nbits - 1; i >= 0; i--) begin
      @(negedge clk);
      if (is_code) begin code_we = 1; code_sdi = val[i]; end
      else         begin addr_we = 1; addr_sdi = val[i]; end
    end
    @(negedge clk);
    code_we = 0; addr_we = 0; code_sdi = 0; addr_sdi = 0;
    repeat (4) @(negedge clk);
    if (nbits < (is_code ? W : AW)) m_ferr = 1;
    else begin
      m_ferr = 0;
      if (is_code) begin
        m_code[m_addr] = W'(val);
        m_fail[m_addr] = 0;
      end else m_addr = val & ((1 << AW) - 1);
    end
  endtask

  task automatic write_ch(input int ch, input int code, input string tag);
    shift_in(0, ch, AW);
    shift_in(1, code, W);
    push(tag);
  endtask

  task automatic pulse_fail(input int ch, input string tag);
    @(negedge clk); fail_in[ch] = 1;
    @(negedge clk); fail_in[ch] = 0;
    repeat (3) @(negedge clk);
    m_fail[ch] = 1;
    push(tag);
  endtask

  task automatic chk(input string tag, input string what,
                     input logic [N*W-1:0] act, input logic [N*W-1:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  // monitor: pops expected items and compares against the outputs
  initial begin
    forever begin
      @(negedge clk); #1;
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk(e.tag, "dac_code",  dac_code, e.dac);
        chk(e.tag, "fail_vec",  (N*W)'(fail_vec), (N*W)'(e.fv));
        chk(e.tag, "any_fail",  (N*W)'(any_fail), (N*W)'(e.any));
        chk(e.tag, "frame_err", (N*W)'(frame_err), (N*W)'(e.ferr));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    push("R6 reset state");
    @(negedge clk);

    write_ch(3, 100, "R5 disabled output zero");
    @(negedge clk); master_en = 1;
    repeat (3) @(negedge clk);
    push("R3 R4 R5 code shows after enable");

    write_ch(0, 127, "R1 R2 ch0 max");
    write_ch(7, 1, "R1 R2 ch7 min step");
    write_ch(5, 0, "R1 ch5 zero code");

    shift_in(0, 2, 2);
    push("R10 short address frame");
    shift_in(1, 55, W);
    push("R4 R10 code follows old address, flag cleared");

    shift_in(1, 'h3A5, 10);
    push("R11 overlong code keeps last bits");

    shift_in(1, 9, 4);
    push("R10 short code frame");

    shift_in(0, 1, AW);
    push("R4 address change keeps stored codes");

    pulse_fail(3, "R7 R8 R9 fail latched and output zero");
    repeat (5) @(negedge clk);
    push("R7 fail stays after input drops");
    pulse_fail(6, "R9 second fail");

    write_ch(3, 9, "R8 rewrite clears fail");

    @(negedge clk); master_en = 0;
    repeat (2) @(negedge clk);
    push("R5 master off all zero");
    @(negedge clk); master_en = 1;
    repeat (2) @(negedge clk);
    push("R5 codes retained after re-enable");

    for (int k = 0; k < N; k++) write_ch(k, (k * 13 + 5) & 127, "R1 all channels");

    @(negedge clk); rst = 1;
    repeat (2) @(negedge clk); rst = 0;
    model_clear();
    repeat (2) @(negedge clk);
    push("R6 mid-run reset");

    write_ch(2, 77, "R3 write after reset");
    repeat (4) @(negedge clk);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule